// File: doc/BRIEF.md
# Dual-Bank A24 Memory Slave Decoder

This block is the slave-side control for a memory board on a 24-bit-address, 16-bit-data backplane bus. The board carries two banks, and each bank holds four byte-wide memory chips. A set of static configuration inputs, one set per bank, tells the block where the bank sits in the address map, what size the chips are, which address-modifier classes it may answer, and how slow its chips are. When a bus cycle hits a bank, the block selects the right chip or chips. It drives active-low chip enable, output enable and write enable, and it answers with an active-low data acknowledge once the chip access time has passed.

The memory arrays and the data path are outside the block. The block handles decoding, chip selection and handshake timing. It also handles protection: a supply-undervoltage flag blocks every write strobe, and it can optionally pull the system reset low. Each bank has a busy indicator, suitable for a front-panel lamp. An overlap flag reports configurations in which both banks claim the same cycle.

Top module: `vme_dual_bank_mem_slave`

## Requirements
- R1: A bank answers when the address lines A23..A15 equal its 9-bit base field (bit i of the field matches A(15+i), and 1 means the line must be 1). Field bits below the region size are ignored. Example: a bank with capacity code 010 and base 0x8E0000 answers 0x8E0000 to 0x8FFFFF and nothing else.
- R2: Capacity code c = 000, 001, 010, 011 or 100 stands for chips of 8K×8 shifted left by c. The bank region is 32 KB shifted left by c and is aligned to its own size. Codes 101, 110 and 111 disable the bank.
- R3: The address modifier is 0x3D for supervisor data, 0x3E for supervisor program, 0x39 for user data and 0x3A for user program. A cycle is accepted only if its space is enabled (data enable or program enable) and, when the bank is set to supervisor-only, the code is a supervisor code. Any other AM value is never accepted.
- R4: Chip enable bit number is bank×4 + pair×2 + lane. Bank 1 is index 0. The pair is address bit A(14+c), which is the upper half of the region. The lane is 0 when DS0 is low and 1 when DS1 is low, and a word access enables both lanes. At most two enables are active at a time.
- R5: During an accepted cycle, output enable is low for reads (WRITE high). Write enable is low for writes (WRITE low). The two are never low together.
- R6: The speed code s (00 = 100 ns up to 11 = 250 ns, in 50 ns steps) gives N = ceil((100 + 50·s) / CLK_PERIOD_NS) wait cycles. DTACK goes low on the Nth rising edge after the first edge that samples AS low, at least one DS low and a hit.
- R7: One edge after an edge that samples both data strobes high, DTACK, all chip enables, output enable and write enable are inactive.
- R8: While the undervoltage input is high, write enable stays high. The cycle is still acknowledged.
- R9: The system reset output is low exactly when undervoltage and the reset-enable input are both high.
- R10: bank_busy[b] is high from the edge that starts a cycle to bank b until that cycle ends. The two busy bits are never high together.
- R11: When both banks accept a cycle, bank 1 serves it and overlap_err is high for the length of that cycle. Otherwise overlap_err is low.
- R12: A cycle that no bank accepts produces no DTACK, no chip enable and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_addr | input | 23 | Address lines A23..A1 |
| vme_am | input | 6 | Address modifier |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, bit 0 = DS0 (low byte), bit 1 = DS1 (high byte) |
| vme_write_n | input | 1 | Low for a write cycle |
| undervolt | input | 1 | Supply below threshold |
| sysreset_en | input | 1 | Allows undervoltage to drive the system reset |
| b1_base | input | 9 | Bank 1 base field for A23..A15 |
| b1_cap | input | 3 | Bank 1 capacity code |
| b1_super_only | input | 1 | Bank 1 accepts supervisor codes only |
| b1_data_en | input | 1 | Bank 1 accepts data-space codes |
| b1_prog_en | input | 1 | Bank 1 accepts program-space codes |
| b1_speed | input | 2 | Bank 1 chip speed code |
| b2_base | input | 9 | Bank 2 base field for A23..A15 |
| b2_cap | input | 3 | Bank 2 capacity code |
| b2_super_only | input | 1 | Bank 2 accepts supervisor codes only |
| b2_data_en | input | 1 | Bank 2 accepts data-space codes |
| b2_prog_en | input | 1 | Bank 2 accepts program-space codes |
| b2_speed | input | 2 | Bank 2 chip speed code |
| dtack_n | output | 1 | Data acknowledge, active low |
| chip_ce_n | output | 8 | Chip enables, active low, indexed per R4 |
| chip_oe_n | output | 1 | Shared output enable, active low |
| chip_we_n | output | 1 | Shared write enable, active low |
| bank_busy | output | 2 | Per-bank access indicator |
| overlap_err | output | 1 | Both banks accepted the current cycle |
| sysreset_n | output | 1 | System reset request, active low |

## Verification
Two things can fall in the same cycle. The bank-priority choice and the write-protect gate can both act on one access, for example when an overlapping configuration meets a write while undervoltage is high. The bench provokes this by placing bank 2 over bank 1 and issuing writes with the flag both low and high. The cycle passes if bank 1's enables and busy appear, overlap_err rises, write enable follows the flag, and the acknowledge delay is bank 1's and not bank 2's. Sweeps over every capacity code, every AM value under all permission settings, and every speed code compute each expected region, chip index and latency arithmetically.

// File: rtl/vmem_pkg.sv
`timescale 1ns/1ps
package vmem_pkg;

   localparam logic [5:0] AM_SUP_DATA = 6'h3D;
   localparam logic [5:0] AM_SUP_PROG = 6'h3E;
   localparam logic [5:0] AM_USR_DATA = 6'h39;
   localparam logic [5:0] AM_USR_PROG = 6'h3A;

   localparam int unsigned BASE_W  = 9;
   localparam int unsigned CAP_W   = 3;
   localparam int unsigned SPD_W   = 2;
   localparam logic [2:0]  CAP_MAX = 3'd4;

   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_WAIT = 2'd1,
      CYC_ACK  = 2'd2
   } cyc_state_t;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [CAP_W-1:0]  cap;
      logic              super_only;
      logic              data_en;
      logic              prog_en;
      logic [SPD_W-1:0]  speed;
   } bank_cfg_t;

   // wait cycles for a speed code, rounded up, never below one
   function automatic int unsigned wait_cycles(input int unsigned code,
                                               input int unsigned fast_ns,
                                               input int unsigned step_ns,
                                               input int unsigned clk_ns);
      int unsigned ns;
      int unsigned n;
      ns = fast_ns + step_ns * code;
      n  = (ns + clk_ns - 1) / clk_ns;
      return (n == 0) ? 1 : n;
   endfunction

endpackage

// File: rtl/vmem_am_filter.sv
`timescale 1ns/1ps
module vmem_am_filter
   import vmem_pkg::*;
(
   input  logic [5:0] am,
   input  logic       super_only,
   input  logic       data_en,
   input  logic       prog_en,
   output logic       ok
);

   always_comb begin
      unique case (am)
         AM_SUP_DATA: ok = data_en;
         AM_SUP_PROG: ok = prog_en;
         AM_USR_DATA: ok = data_en & ~super_only;
         AM_USR_PROG: ok = prog_en & ~super_only;
         default:     ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/vmem_bank_decode.sv
`timescale 1ns/1ps
module vmem_bank_decode
   import vmem_pkg::*;
(
   input  logic [23:1]  addr,
   input  logic [5:0]   am,
   input  bank_cfg_t    cfg,
   output logic         hit,
   output logic         pair
);

   logic              am_ok;
   logic              size_ok;
   logic              base_ok;
   logic [BASE_W-1:0] cmp_mask;
   logic [BASE_W-1:0] diff;

   vmem_am_filter u_am (
      .am         (am),
      .super_only (cfg.super_only),
      .data_en    (cfg.data_en),
      .prog_en    (cfg.prog_en),
      .ok         (am_ok)
   );

   always_comb begin
      size_ok  = (cfg.cap <= CAP_MAX);
      cmp_mask = {BASE_W{1'b1}} << cfg.cap;
      diff     = addr[23:15] ^ cfg.base;
      base_ok  = ((diff & cmp_mask) == '0);
      unique case (cfg.cap)
         3'd0:    pair = addr[14];
         3'd1:    pair = addr[15];
         3'd2:    pair = addr[16];
         3'd3:    pair = addr[17];
         3'd4:    pair = addr[18];
         default: pair = 1'b0;
      endcase
      hit = size_ok & base_ok & am_ok;
   end

endmodule

// File: rtl/vmem_cycle_ctrl.sv
`timescale 1ns/1ps
module vmem_cycle_ctrl
   import vmem_pkg::*;
#(
   parameter int unsigned NUM_BANKS      = 2,
   parameter int unsigned CHIPS_PER_BANK = 4,
   parameter int unsigned WAIT_W         = 3,
   localparam int unsigned SEL_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned CE_W          = NUM_BANKS * CHIPS_PER_BANK
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      as_n,
   input  logic [1:0]                ds_n,
   input  logic                      write_n,
   input  logic                      undervolt,
   input  logic [NUM_BANKS-1:0]      hit,
   input  logic [NUM_BANKS-1:0]      pair,
   input  logic [WAIT_W-1:0]         bank_wait [NUM_BANKS],
   output logic                      dtack_n,
   output logic [CE_W-1:0]           ce_n,
   output logic                      oe_n,
   output logic                      we_n,
   output logic [NUM_BANKS-1:0]      busy,
   output logic                      overlap
);

   cyc_state_t        state_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [CE_W-1:0]   ce_q;
   logic [CE_W-1:0]   ce_next;
   logic [SEL_W-1:0]  sel_q;
   logic [SEL_W-1:0]  start_sel;
   logic              wr_q;
   logic              ovl_q;
   logic              dtack_q;
   logic              strobe_on;
   logic              strobe_off;
   logic              start;
   logic              active;

   always_comb begin
      strobe_on  = ~as_n & (ds_n != 2'b11);
      strobe_off = (ds_n == 2'b11);
      start      = strobe_on & (|hit);
      start_sel  = '0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (hit[b]) start_sel = SEL_W'(b);
      end
      ce_next = '1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int k = 0; k < CHIPS_PER_BANK; k++) begin
            if (start_sel == SEL_W'(b) && (k / 2) == int'(pair[b])) begin
               ce_next[b*CHIPS_PER_BANK + k] = ds_n[k % 2];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CYC_IDLE;
         cnt_q   <= '0;
         ce_q    <= '1;
         sel_q   <= '0;
         wr_q    <= 1'b0;
         ovl_q   <= 1'b0;
         dtack_q <= 1'b1;
      end else begin
         unique case (state_q)
            CYC_IDLE: begin
               if (start) begin
                  state_q <= CYC_WAIT;
                  sel_q   <= start_sel;
                  cnt_q   <= bank_wait[start_sel] - 1'b1;
                  ce_q    <= ce_next;
                  wr_q    <= ~write_n;
                  ovl_q   <= ($countones(hit) > 1);
               end
            end
            CYC_WAIT: begin
               if (strobe_off || as_n) begin
                  state_q <= CYC_IDLE;
                  ce_q    <= '1;
                  wr_q    <= 1'b0;
                  ovl_q   <= 1'b0;
               end else if (cnt_q == '0) begin
                  state_q <= CYC_ACK;
                  dtack_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CYC_ACK: begin
               if (strobe_off) begin
                  state_q <= CYC_IDLE;
                  dtack_q <= 1'b1;
                  ce_q    <= '1;
                  wr_q    <= 1'b0;
                  ovl_q   <= 1'b0;
               end
            end
            default: state_q <= CYC_IDLE;
         endcase
      end
   end

   always_comb begin
      active  = (state_q != CYC_IDLE);
      dtack_n = dtack_q;
      ce_n    = ce_q;
      oe_n    = ~(active & ~wr_q);
      we_n    = ~(active & wr_q & ~undervolt);
      overlap = active & ovl_q;
      for (int b = 0; b < NUM_BANKS; b++) begin
         busy[b] = active && (sel_q == SEL_W'(b));
      end
   end

endmodule

// File: rtl/vme_dual_bank_mem_slave.sv
`timescale 1ns/1ps
module vme_dual_bank_mem_slave
   import vmem_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS  = 50,
   parameter int unsigned FASTEST_NS     = 100,
   parameter int unsigned SPEED_STEP_NS  = 50,
   parameter int unsigned CHIPS_PER_BANK = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [23:1] vme_addr,
   input  logic [5:0]  vme_am,
   input  logic        vme_as_n,
   input  logic [1:0]  vme_ds_n,
   input  logic        vme_write_n,
   input  logic        undervolt,
   input  logic        sysreset_en,
   input  logic [8:0]  b1_base,
   input  logic [2:0]  b1_cap,
   input  logic        b1_super_only,
   input  logic        b1_data_en,
   input  logic        b1_prog_en,
   input  logic [1:0]  b1_speed,
   input  logic [8:0]  b2_base,
   input  logic [2:0]  b2_cap,
   input  logic        b2_super_only,
   input  logic        b2_data_en,
   input  logic        b2_prog_en,
   input  logic [1:0]  b2_speed,
   output logic        dtack_n,
   output logic [7:0]  chip_ce_n,
   output logic        chip_oe_n,
   output logic        chip_we_n,
   output logic [1:0]  bank_busy,
   output logic        overlap_err,
   output logic        sysreset_n
);

   localparam int unsigned NUM_BANKS   = 2;
   localparam int unsigned NUM_SPEEDS  = 1 << SPD_W;
   localparam int unsigned MAX_WAIT    =
      wait_cycles(NUM_SPEEDS - 1, FASTEST_NS, SPEED_STEP_NS, CLK_PERIOD_NS);
   localparam int unsigned WAIT_W      = $clog2(MAX_WAIT + 1);

   if (CLK_PERIOD_NS == 0) begin : g_bad_clk
      $error("CLK_PERIOD_NS must be nonzero");
   end
   if (CHIPS_PER_BANK != 4) begin : g_bad_chips
      $error("CHIPS_PER_BANK must be 4: two byte lanes times two pairs");
   end
   if (FASTEST_NS == 0) begin : g_bad_fast
      $error("FASTEST_NS must be nonzero");
   end

   bank_cfg_t         cfg       [NUM_BANKS];
   logic [WAIT_W-1:0] wait_tab  [NUM_SPEEDS];
   logic [WAIT_W-1:0] bank_wait [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit;
   logic [NUM_BANKS-1:0] pair;

   assign cfg[0] = '{base: b1_base, cap: b1_cap, super_only: b1_super_only,
                     data_en: b1_data_en, prog_en: b1_prog_en, speed: b1_speed};
   assign cfg[1] = '{base: b2_base, cap: b2_cap, super_only: b2_super_only,
                     data_en: b2_data_en, prog_en: b2_prog_en, speed: b2_speed};

   for (genvar s = 0; s < NUM_SPEEDS; s++) begin : g_wait
      assign wait_tab[s] =
         WAIT_W'(wait_cycles(s, FASTEST_NS, SPEED_STEP_NS, CLK_PERIOD_NS));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_wait[b] = wait_tab[cfg[b].speed];
      vmem_bank_decode u_dec (
         .addr (vme_addr),
         .am   (vme_am),
         .cfg  (cfg[b]),
         .hit  (hit[b]),
         .pair (pair[b])
      );
   end

   vmem_cycle_ctrl #(
      .NUM_BANKS      (NUM_BANKS),
      .CHIPS_PER_BANK (CHIPS_PER_BANK),
      .WAIT_W         (WAIT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_n      (vme_as_n),
      .ds_n      (vme_ds_n),
      .write_n   (vme_write_n),
      .undervolt (undervolt),
      .hit       (hit),
      .pair      (pair),
      .bank_wait (bank_wait),
      .dtack_n   (dtack_n),
      .ce_n      (chip_ce_n),
      .oe_n      (chip_oe_n),
      .we_n      (chip_we_n),
      .busy      (bank_busy),
      .overlap   (overlap_err)
   );

   assign sysreset_n = ~(undervolt & sysreset_en);

endmodule

// File: rtl/vmem_slave_chk.sv
`timescale 1ns/1ps
module vmem_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] vme_ds_n,
   input logic       undervolt,
   input logic       dtack_n,
   input logic [7:0] chip_ce_n,
   input logic       chip_oe_n,
   input logic       chip_we_n,
   input logic [1:0] bank_busy
);

   p_we_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      undervolt |-> chip_we_n);

   p_dtack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vme_ds_n == 2'b11) |=> dtack_n);

   p_ce_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vme_ds_n == 2'b11) |=> (&chip_ce_n));

   p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_busy[0] && bank_busy[1]));

   p_ce_bank1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_ce_n[3:0] != 4'hF) |-> bank_busy[0]);

   p_ce_bank2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_ce_n[7:4] != 4'hF) |-> bank_busy[1]);

   p_ce_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~chip_ce_n) <= 2);

   p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!chip_oe_n && !chip_we_n));

   p_dtack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n |-> (|bank_busy));

endmodule

bind vme_dual_bank_mem_slave vmem_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vme_ds_n  (vme_ds_n),
   .undervolt (undervolt),
   .dtack_n   (dtack_n),
   .chip_ce_n (chip_ce_n),
   .chip_oe_n (chip_oe_n),
   .chip_we_n (chip_we_n),
   .bank_busy (bank_busy)
);

// File: tb/vme_dual_bank_mem_slave_tb.sv
`timescale 1ns/1ps
module vme_dual_bank_mem_slave_tb;

   localparam int CLK_PERIOD = 50;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:1] vme_addr = '0;
   logic [5:0]  vme_am = '0;
   logic        vme_as_n = 1'b1;
   logic [1:0]  vme_ds_n = 2'b11;
   logic        vme_write_n = 1'b1;
   logic        undervolt = 1'b0;
   logic        sysreset_en = 1'b0;
   logic [8:0]  cb_base [2];
   logic [2:0]  cb_cap  [2];
   logic        cb_sup  [2];
   logic        cb_dat  [2];
   logic        cb_prg  [2];
   logic [1:0]  cb_spd  [2];
   logic        dtack_n;
   logic [7:0]  chip_ce_n;
   logic        chip_oe_n;
   logic        chip_we_n;
   logic [1:0]  bank_busy;
   logic        overlap_err;
   logic        sysreset_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vme_dual_bank_mem_slave #(.CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
      .clk(clk), .rst_n(rst_n), .vme_addr(vme_addr), .vme_am(vme_am),
      .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n), .vme_write_n(vme_write_n),
      .undervolt(undervolt), .sysreset_en(sysreset_en),
      .b1_base(cb_base[0]), .b1_cap(cb_cap[0]), .b1_super_only(cb_sup[0]),
      .b1_data_en(cb_dat[0]), .b1_prog_en(cb_prg[0]), .b1_speed(cb_spd[0]),
      .b2_base(cb_base[1]), .b2_cap(cb_cap[1]), .b2_super_only(cb_sup[1]),
      .b2_data_en(cb_dat[1]), .b2_prog_en(cb_prg[1]), .b2_speed(cb_spd[1]),
      .dtack_n(dtack_n), .chip_ce_n(chip_ce_n), .chip_oe_n(chip_oe_n),
      .chip_we_n(chip_we_n), .bank_busy(bank_busy), .overlap_err(overlap_err),
      .sysreset_n(sysreset_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // R2: region bytes and aligned start; -1 when the code disables the bank
   function automatic int region_lo(input int b);
      int size;
      if (cb_cap[b] > 3'd4) return -1;
      size = 32768 << cb_cap[b];
      return (int'(cb_base[b]) << 15) & ~(size - 1);
   endfunction

   function automatic bit in_bank(input int b, input int a);
      int lo;
      lo = region_lo(b);
      if (lo < 0) return 1'b0;
      return (a >= lo) && (a < lo + (32768 << cb_cap[b]));
   endfunction

   // R3 code table
   function automatic bit am_ok(input int b, input logic [5:0] am);
      case (am)
         6'h3D:   return cb_dat[b];
         6'h3E:   return cb_prg[b];
         6'h39:   return cb_dat[b] && !cb_sup[b];
         6'h3A:   return cb_prg[b] && !cb_sup[b];
         default: return 1'b0;
      endcase
   endfunction

   // R4 expected enables
   function automatic logic [7:0] exp_ce(input int b, input int a, input logic [1:0] ds);
      logic [7:0] m;
      int half, p;
      half = (32768 << cb_cap[b]) / 2;
      p    = ((a - region_lo(b)) >= half) ? 1 : 0;
      m    = '0;
      if (!ds[0]) m[b*4 + p*2]     = 1'b1;
      if (!ds[1]) m[b*4 + p*2 + 1] = 1'b1;
      return ~m;
   endfunction

   // R6 latency
   function automatic int exp_n(input int b);
      return (100 + 50 * int'(cb_spd[b]) + CLK_PERIOD - 1) / CLK_PERIOD;
   endfunction

   task automatic access(input int a, input logic [5:0] am,
                         input logic [1:0] ds, input bit wr);
      bit h0, h1, any;
      int eb, hi_cnt;
      h0  = in_bank(0, a) && am_ok(0, am);
      h1  = in_bank(1, a) && am_ok(1, am);
      any = h0 || h1;
      eb  = h0 ? 0 : 1;
      @(negedge clk);
      vme_addr    = a[23:1];
      vme_am      = am;
      vme_write_n = !wr;
      vme_as_n    = 1'b0;
      vme_ds_n    = ds;
      @(negedge clk);
      if (any) begin
         chk(chip_ce_n == exp_ce(eb, a, ds), "R4", "chip enables", chip_ce_n, exp_ce(eb, a, ds));
         chk(bank_busy == (2'b01 << eb), "R10", "busy", bank_busy, 1 << eb);
         chk(chip_oe_n == wr, "R5", "oe_n", chip_oe_n, wr);
         chk(chip_we_n == (!wr || undervolt), "R8", "we_n", chip_we_n, !wr || undervolt);
         chk(overlap_err == (h0 && h1), "R11", "overlap", overlap_err, h0 && h1);
      end else begin
         chk(chip_ce_n == 8'hFF, "R12", "enables on miss", chip_ce_n, 8'hFF);
         chk(bank_busy == 2'b00, "R12", "busy on miss", bank_busy, 0);
      end
      hi_cnt = 0;
      for (int i = 0; i < 12; i++) begin
         if (!dtack_n) break;
         hi_cnt++;
         @(negedge clk);
      end
      if (any) chk(hi_cnt == exp_n(eb), "R6", "dtack latency", hi_cnt, exp_n(eb));
      else     chk(hi_cnt == 12, "R12", "no dtack on miss", hi_cnt, 12);
      vme_ds_n = 2'b11;
      @(negedge clk);
      chk(dtack_n == 1'b1, "R7", "dtack released", dtack_n, 1);
      chk(chip_ce_n == 8'hFF && chip_oe_n && chip_we_n, "R7", "strobes released",
          {chip_ce_n, chip_oe_n, chip_we_n}, 10'h3FF);
      chk(bank_busy == 2'b00 && !overlap_err, "R10", "busy clear", bank_busy, 0);
      vme_as_n = 1'b1;
   endtask

   task automatic set_bank(input int b, input logic [8:0] base, input logic [2:0] cap,
                           input bit sup, input bit dat, input bit prg, input logic [1:0] spd);
      cb_base[b] = base; cb_cap[b] = cap; cb_sup[b] = sup;
      cb_dat[b] = dat; cb_prg[b] = prg; cb_spd[b] = spd;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] ds_pat [3];
      ds_pat[0] = 2'b00; ds_pat[1] = 2'b10; ds_pat[2] = 2'b01;
      set_bank(0, 9'h11C, 3'd2, 1'b0, 1'b1, 1'b1, 2'd3);
      set_bank(1, 9'h040, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0);
      repeat (3) @(negedge clk);
      // reset state
      chk(dtack_n == 1'b1, "R7", "reset dtack", dtack_n, 1);
      chk(chip_ce_n == 8'hFF, "R12", "reset enables", chip_ce_n, 8'hFF);
      chk(bank_busy == 2'b00 && !overlap_err, "R10", "reset busy", bank_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 example region edges
      access(24'h8DFFFE, 6'h39, 2'b00, 1'b0);
      access(24'h8E0000, 6'h39, 2'b00, 1'b0);
      access(24'h8EFFFE, 6'h39, 2'b10, 1'b0);
      access(24'h8F0000, 6'h39, 2'b01, 1'b1);
      access(24'h8FFFFE, 6'h39, 2'b00, 1'b1);
      access(24'h900000, 6'h39, 2'b00, 1'b0);

      // R2 sweep over every capacity code, unaligned base bits set
      for (int c = 0; c < 8; c++) begin
         int size, lo;
         set_bank(0, 9'h155, 3'(c), 1'b0, 1'b1, 1'b1, 2'(c % 4));
         size = 32768 << (c > 4 ? 0 : c);
         lo   = (c > 4) ? ((9'h155 << 15) & ~(32767)) : region_lo(0);
         access(lo - 2,            6'h3D, ds_pat[c % 3], c[0]);
         access(lo,                6'h3D, ds_pat[(c+1) % 3], c[1]);
         access(lo + size/2 - 2,   6'h3E, ds_pat[(c+2) % 3], 1'b0);
         access(lo + size/2,       6'h3A, ds_pat[c % 3], 1'b1);
         access(lo + size - 2,     6'h39, 2'b00, 1'b0);
         access(lo + size,         6'h39, 2'b00, 1'b0);
      end

      // R3 every AM code under every permission setting
      for (int p = 0; p < 8; p++) begin
         set_bank(0, 9'h11C, 3'd2, p[2], p[1], p[0], 2'd0);
         for (int am = 0; am < 64; am++) begin
            access(24'h8E4000, 6'(am), 2'b00, 1'b0);
         end
      end

      // R6 bank 2 at every speed, both pairs
      set_bank(0, 9'h11C, 3'd2, 1'b0, 1'b1, 1'b1, 2'd3);
      for (int s = 0; s < 4; s++) begin
         cb_spd[1] = 2'(s);
         access(24'h200000, 6'h39, 2'b10, 1'b0);
         access(24'h204002, 6'h39, 2'b01, 1'b1);
      end

      // R11 overlap combined with R8 undervoltage write gating
      set_bank(1, 9'h11C, 3'd1, 1'b0, 1'b1, 1'b1, 2'd0);
      access(24'h8E2000, 6'h39, 2'b00, 1'b1);
      undervolt = 1'b1;
      access(24'h8E6000, 6'h39, 2'b00, 1'b1);
      access(24'h8E6000, 6'h39, 2'b00, 1'b0);
      undervolt = 1'b0;
      cb_dat[0] = 1'b0;
      access(24'h8E6000, 6'h39, 2'b10, 1'b1);
      cb_dat[0] = 1'b1;

      // R9 reset request
      for (int k = 0; k < 4; k++) begin
         undervolt   = k[0];
         sysreset_en = k[1];
         #1;
         chk(sysreset_n == !(k[0] && k[1]), "R9", "sysreset_n", sysreset_n, !(k[0] && k[1]));
      end
      undervolt = 1'b0;
      sysreset_en = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule